// File: doc/BRIEF.md
# Limit-Compare System Counter Timer

The block is a memory-mapped up-counter with a 32-bit register view. Each pulse on the tick input moves the count on by one step, where one step is worth bit 9 of the register value. Bits 8:0 of the count always read as zero. The count runs up to a programmable limit. On the tick where the count equals that limit, the count drops back to zero, a sticky reached flag is set and a level interrupt is raised. A limit of zero turns the block into a free-running counter that wraps at 0x7FFFFE00.

Software reaches the block through a plain synchronous bus. The bus has a 3-bit word index, separate read and write strobes, write data and registered read data. Software programs the limit in one of two ways. One write restarts the count. The other write keeps the current count. Software reads the count together with the reached flag, and it acknowledges the interrupt by reading the limit back.

Top module: `lc_sys_timer`

## Requirements
- R1: After reset the limit is zero, the count is zero, the reached flag and `irq_o` are low, and `rdata_o` is zero.
- R2: Each cycle with `tick_i` high adds one step to the count, that is 0x200 in register terms. Without a tick and without a limit write the count holds. Bits 8:0 of `rdata_o` are always zero.
- R3: A read of word index 1 returns the reached flag in bit 31, the count in bits 30:9 and zeros in bits 8:0. `rdata_o` takes this value in the cycle after the read strobe.
- R4: A write to word index 0 stores `wdata_i & 0x7FFFFE00` as the limit, sets the count to zero and clears the reached flag and `irq_o`. When it meets a tick in the same cycle, the write wins.
- R5: A write to word index 2 stores `wdata_i & 0x7FFFFE00` as the limit and leaves the count and the reached flag unchanged.
- R6: With a nonzero limit, a tick that finds the count equal to the limit sets the count to zero and sets the reached flag. The count therefore restarts every limit+1 ticks.
- R7: With a limit of zero the terminal count is 0x7FFFFE00. Below that value, ticks never set the reached flag.
- R8: A read of word index 0 returns the stored limit with bit 31 zero and clears the reached flag and `irq_o` in the next cycle. If a reload happens in the same cycle, the reload wins and the flag stays set.
- R9: `irq_o` always equals the reached flag. Once set, it stays high through ticks and counter reads until a limit read or a limit write clears it.
- R10: Reads of word indices 3 to 7 return zero. Writes to indices 1 and 3 to 7 change neither the count, the limit nor the flag.
- R11: If a write to word index 2 leaves the count above the new limit, the count keeps rising without setting the flag. It wraps to zero after 0x7FFFFE00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| addr_i | input | 3 | Word index of the register accessed |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level interrupt, mirrors the reached flag |

## Verification
Every state change is due exactly one clock edge after the strobe or tick that causes it. This holds for the count, the limit, the reached flag and `irq_o`. Read data also appears in `rdata_o` one edge after the read strobe. A read returns the state as it stood before that edge, so the read value ignores a tick or clear in the same cycle. The bench drives inputs away from the rising edge. It computes the pre-edge read value and the post-edge state from its own model, then samples two nanoseconds after the rising edge. Same-cycle collisions are run on purpose: a limit write against a tick, and a limit read against a reload.

// File: rtl/lc_tmr_pkg.sv
package lc_tmr_pkg;
  typedef enum logic [2:0] {
    REG_LIMIT    = 3'd0,
    REG_COUNT    = 3'd1,
    REG_LIMIT_NR = 3'd2,
    REG_RSV3     = 3'd3,
    REG_RSV4     = 3'd4,
    REG_RSV5     = 3'd5,
    REG_RSV6     = 3'd6,
    REG_RSV7     = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic wr_limit;
    logic wr_limit_nr;
    logic rd_limit;
    logic rd_count;
    logic rd_any;
  } acc_s;
endpackage

// File: rtl/lc_tmr_decode.sv
module lc_tmr_decode
  import lc_tmr_pkg::*;
(
  input  logic [2:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  output acc_s       acc_o
);
  reg_idx_e idx;

  always_comb begin
    idx               = reg_idx_e'(addr_i);
    acc_o.wr_limit    = wr_en_i && (idx == REG_LIMIT);
    acc_o.wr_limit_nr = wr_en_i && (idx == REG_LIMIT_NR);
    acc_o.rd_limit    = rd_en_i && (idx == REG_LIMIT);
    acc_o.rd_count    = rd_en_i && (idx == REG_COUNT);
    acc_o.rd_any      = rd_en_i;
  end
endmodule

// File: rtl/lc_tmr_core.sv
module lc_tmr_core
  import lc_tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STEP_LSB = 9,
  localparam int CNT_W   = DATA_W - 1 - STEP_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  acc_s              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [DATA_W-1:0] limit_o,
  output logic              reached_o
);
  localparam logic [DATA_W-1:0] LIM_MASK = {1'b0, {CNT_W{1'b1}}, {STEP_LSB{1'b0}}};

  logic [CNT_W-1:0]  count_q;
  logic [DATA_W-1:0] limit_q;
  logic              reached_q;
  logic [CNT_W-1:0]  lim_steps;
  logic [CNT_W-1:0]  term;
  logic              hit;

  always_comb begin
    lim_steps = limit_q[DATA_W-2:STEP_LSB];
    term      = (lim_steps == '0) ? {CNT_W{1'b1}} : lim_steps;
    hit       = tick_i && (count_q == term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      limit_q   <= '0;
      reached_q <= 1'b0;
    end else begin
      if (acc_i.wr_limit || acc_i.wr_limit_nr) limit_q <= wdata_i & LIM_MASK;

      if (acc_i.wr_limit)  count_q <= '0;
      else if (hit)        count_q <= '0;
      else if (tick_i)     count_q <= count_q + CNT_W'(1);

      // limit write beats reload; reload beats acknowledge
      if (acc_i.wr_limit)      reached_q <= 1'b0;
      else if (hit)            reached_q <= 1'b1;
      else if (acc_i.rd_limit) reached_q <= 1'b0;
    end
  end

  assign count_o   = count_q;
  assign limit_o   = limit_q;
  assign reached_o = reached_q;
endmodule

// File: rtl/lc_tmr_rdmux.sv
module lc_tmr_rdmux
  import lc_tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STEP_LSB = 9,
  localparam int CNT_W   = DATA_W - 1 - STEP_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_s              acc_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic              reached_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    if (acc_i.rd_count)      rd_val = {reached_i, count_i, {STEP_LSB{1'b0}}};
    else if (acc_i.rd_limit) rd_val = {1'b0, limit_i[DATA_W-2:0]};
    else                     rd_val = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdata_o <= '0;
    else if (acc_i.rd_any) rdata_o <= rd_val;
  end
endmodule

// File: rtl/lc_sys_timer.sv
module lc_sys_timer
  import lc_tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STEP_LSB = 9,
  localparam int CNT_W   = DATA_W - 1 - STEP_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  acc_s              acc;
  logic [CNT_W-1:0]  count_w;
  logic [DATA_W-1:0] limit_w;
  logic              reached_w;

  lc_tmr_decode i_decode (
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .acc_o   (acc)
  );

  lc_tmr_core #(.DATA_W(DATA_W), .STEP_LSB(STEP_LSB)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .acc_i     (acc),
    .wdata_i   (wdata_i),
    .count_o   (count_w),
    .limit_o   (limit_w),
    .reached_o (reached_w)
  );

  lc_tmr_rdmux #(.DATA_W(DATA_W), .STEP_LSB(STEP_LSB)) i_rdmux (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .count_i   (count_w),
    .limit_i   (limit_w),
    .reached_i (reached_w),
    .rdata_o   (rdata_o)
  );

  assign irq_o = reached_w;
endmodule

// File: rtl/lc_tmr_chk.sv
module lc_tmr_chk #(
  parameter int DATA_W   = 32,
  parameter int STEP_LSB = 9,
  localparam int CNT_W   = DATA_W - 1 - STEP_LSB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [2:0]        addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [CNT_W-1:0]  count_i,
  input logic [DATA_W-1:0] limit_i
);
  // R4
  limit_wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd0) |=> (count_i == '0 && !irq_o));

  // R2
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(count_i));

  // R2
  rdata_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[STEP_LSB-1:0] == '0);

  // R8
  limit_rd_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == 3'd0 && !tick_i) |=> !irq_o);

  // R9
  irq_rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && limit_i != '0 && count_i == limit_i[DATA_W-2:STEP_LSB])
      |=> (count_i == '0 && irq_o));

  // R7
  freerun_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && limit_i == '0 && (&count_i)) |=> (count_i == '0 && irq_o));
endmodule

bind lc_sys_timer lc_tmr_chk #(.DATA_W(DATA_W), .STEP_LSB(STEP_LSB)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .addr_i  (addr_i),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .count_i (count_w),
  .limit_i (limit_w)
);

// File: tb/test_lc_sys_timer.sv
`timescale 1ns/1ps
module test_lc_sys_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [21:0] m_cnt;
  logic [31:0] m_lim;
  logic        m_rch;

  always #10 clk = ~clk;

  lc_sys_timer i_lc_sys_timer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    if (a == 3'd1)      return {m_rch, m_cnt, 9'd0};
    else if (a == 3'd0) return {1'b0, m_lim[30:0]};
    else                return 32'd0;
  endfunction

  function automatic logic [21:0] term_of(input logic [31:0] lim);
    return (lim[30:9] == 22'd0) ? 22'h3FFFFF : lim[30:9];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  // one bus cycle; inputs driven 2 ns after a rising edge, results sampled 2 ns after the next
  task automatic cyc(input bit tk, input bit wr, input bit rd, input logic [2:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] er;
    logic        hit;
    er = exp_read(a);
    tick_i = tk; wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
    @(posedge clk);
    hit = tk && (m_cnt == term_of(m_lim));
    if (wr && (a == 3'd0 || a == 3'd2)) m_lim = d & 32'h7FFFFE00;
    if (wr && a == 3'd0) begin m_cnt = 0; m_rch = 0; end
    else begin
      if (hit) m_cnt = 0; else if (tk) m_cnt = m_cnt + 22'd1;
      if (hit) m_rch = 1; else if (rd && a == 3'd0) m_rch = 0;
    end
    #2;
    tick_i = 0; wr_en_i = 0; rd_en_i = 0;
    check({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_rch});
    if (rd) check({tag, " rdata"}, rdata_o, er);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_cnt = 0; m_lim = 0; m_rch = 0;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    // R1
    check("R1 rdata", rdata_o, 32'd0);
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    cyc(0, 0, 1, 3'd1, 0, "R1 count");
    cyc(0, 0, 1, 3'd0, 0, "R1 limit");
    // R2 R7: free-run stepping, no flag
    ticks(5, "R7");
    cyc(0, 0, 0, 3'd0, 0, "R2 idle");
    cyc(0, 0, 1, 3'd1, 0, "R2 count");
    check("R2 step", rdata_o, 32'h0000_0A00);
    // R4: write with tick collides, masking
    cyc(1, 1, 0, 3'd0, 32'hFFFF_FFFF, "R4 wr");
    cyc(0, 0, 1, 3'd1, 0, "R4 count zero");
    cyc(0, 0, 1, 3'd0, 0, "R4 limit mask");
    check("R4 mask", rdata_o, 32'h7FFF_FE00);
    // R6: limit 3 steps
    cyc(0, 1, 0, 3'd0, 32'h0000_07FF, "R6 wr");
    ticks(3, "R6 pre");
    cyc(0, 0, 1, 3'd1, 0, "R6 at limit");
    ticks(1, "R6 reload");
    check("R6 irq", {31'd0, irq_o}, 32'd1);
    cyc(0, 0, 1, 3'd1, 0, "R3 reached bit");
    check("R3 value", rdata_o, 32'h8000_0000);
    // R9: stays high through ticks and count reads
    ticks(2, "R9 hold");
    cyc(0, 0, 1, 3'd1, 0, "R9 count read");
    // R8: ack
    cyc(0, 0, 1, 3'd0, 0, "R8 ack");
    check("R8 limit val", rdata_o, 32'h0000_0600);
    // R8: reload in same cycle as ack wins (count now 2 of 3)
    ticks(1, "R8 pre");
    cyc(1, 0, 1, 3'd0, 0, "R8 collide");
    check("R8 collide irq", {31'd0, irq_o}, 32'd1);
    cyc(0, 0, 1, 3'd0, 0, "R8 clear");
    // R5 R11: no-reset update below current count
    cyc(0, 1, 0, 3'd0, 32'd100 << 9, "R5 wr");
    ticks(50, "R5 run");
    cyc(0, 1, 0, 3'd2, 32'd10 << 9, "R5 wr nr");
    cyc(0, 0, 1, 3'd1, 0, "R5 kept");
    check("R5 kept val", rdata_o, 32'd50 << 9);
    ticks(20, "R11 run");
    cyc(0, 0, 1, 3'd1, 0, "R11 above");
    check("R11 val", rdata_o, 32'd70 << 9);
    // R10: unused indices
    for (int a = 3; a < 8; a++) begin
      cyc(0, 1, 0, 3'(a), 32'hFFFF_FFFF, "R10 wr");
      cyc(0, 0, 1, 3'(a), 0, "R10 rd");
    end
    cyc(0, 1, 0, 3'd1, 32'hFFFF_FFFF, "R10 wr idx1");
    cyc(0, 0, 1, 3'd1, 0, "R10 count unchanged");
    cyc(0, 0, 1, 3'd0, 0, "R10 limit unchanged");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      bit tk;
      op = $urandom % 100;
      tk = ($urandom % 2) == 1;
      if (op < 8)       cyc(tk, 1, 0, 3'd0, (($urandom % 24) << 9) | ($urandom & 32'h8000_01FF), "R4 rnd");
      else if (op < 12) cyc(tk, 1, 0, 3'd2, ($urandom % 24) << 9, "R5 rnd");
      else if (op < 16) cyc(tk, 1, 0, 3'($urandom % 8), $urandom, "R10 rnd");
      else if (op < 34) cyc(tk, 0, 1, 3'($urandom % 8), 0, "R3 rnd");
      else              cyc(tk, 0, 0, 3'd0, 0, "R9 rnd");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule